// File: doc/BRIEF.md
# Second-Order Clock-Recovery Loop Filter

This block sits between the early/late phase detector of a clock-and-data recovery loop and a 64-step phase interpolator. Once per update period (4 ns, one cycle of the 250 MHz filter clock), the detector may present a signed vote from -4 to +4. The vote sums how many early and late decisions the detector made. The filter turns the stream of votes into a 6-bit interpolator phase code. That code picks one of 64 equally spaced clock phases covering a full cycle, and it wraps around in both directions.

The loop is second order, with two poles and one zero. A proportional path moves the phase at once by K·(1−1/M)·vote interpolator steps. An integral path adds K/M·vote into a frequency register. The frequency register is added to the phase accumulator on every update, so the loop can track a constant frequency offset between the transmitter and the local reference. The gains are fixed at K = 1/2 and M = 32. Both registers hold 8 fractional bits. With these gains every contribution is an exact multiple of 1/256 step, so no rounding occurs.

Top module: `cdr_loop_filter`

## Requirements
- R1: Reset (rst_n low) clears the phase accumulator and the frequency register. After reset, phase_code reads 0.
- R2: vote_sm is sign-magnitude. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. A magnitude of 5 to 7 counts as 4, and a negative zero (4'b1000) counts as 0.
- R3: Without vote_vld, phase_code and the internal state keep their values, whatever vote_sm holds.
- R4: On each valid vote v, the frequency register (in units of 1/256 step) grows by 4·v, that is by v/64 step.
- R5: On each valid vote, the phase accumulator (14 bits, 8 of them fractional) grows by the updated frequency plus 124·v units (31/64·v steps). phase_code equals the top 6 bits of the accumulator one clock after the vote is sampled.
- R6: The phase accumulator wraps modulo 64 steps in both directions, so phase_code goes from 63 to 0 when increasing and from 0 to 63 when decreasing.
- R7: The frequency register saturates at +8 and −8 steps per update (±2048 units) rather than wrapping. Further votes in the same direction leave it at the limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Update clock, one update period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| vote_vld | input | 1 | vote_sm carries a detector vote this cycle |
| vote_sm | input | 4 | Sign-magnitude vote, bit 3 sign, bits 2:0 magnitude |
| phase_code | output | 6 | Interpolator phase index, 0 to 63 |

## Verification
The frequency register cannot be seen directly. A wrong frequency value shows up at the ports only as drift: every later update then moves phase_code by a wrong amount. A small error can stay hidden below the 8 fractional bits for several updates before it crosses a step boundary. For that reason, long runs of constant votes and runs that drive the register into saturation are compared update by update against an exact integer model. Idle cycles with changing vote_sm check that no state moves without vote_vld.

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
  parameter int CODE_W      = 6,
  parameter int FRAC_W      = 8,
  parameter int LOG2M       = 5,
  parameter int FSAT_STEPS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vote_vld,
  input  logic [3:0]        vote_sm,
  output logic [CODE_W-1:0] phase_code
);
  localparam int PH_W   = CODE_W + FRAC_W;
  localparam int FR_W   = FRAC_W + 5;
  localparam int W      = PH_W + 2;
  localparam int INT_SH = FRAC_W - 1 - LOG2M;
  localparam int INT_I  = 1 << INT_SH;
  localparam int PROP_I = ((1 << LOG2M) - 1) << INT_SH;
  localparam int FSAT_I = FSAT_STEPS << FRAC_W;
  localparam logic signed [W-1:0] INT_C    = W'(INT_I);
  localparam logic signed [W-1:0] PROP_C   = W'(PROP_I);
  localparam logic signed [W-1:0] FSAT_P   = W'(FSAT_I);
  localparam logic signed [W-1:0] FSAT_N   = -W'(FSAT_I);
  localparam logic signed [W-1:0] STEP_MAX = W'(4 * INT_I);

  logic [PH_W-1:0]        ph;
  logic [FR_W-1:0]        freq;
  logic [2:0]             mag;
  logic signed [3:0]      vote_s;
  logic signed [W-1:0]    vote_w, freq_ext, fr_sum, fr_sat, inc, prop;
  logic [PH_W-1:0]        ph_nx;

  assign mag      = (vote_sm[2:0] > 3'd4) ? 3'd4 : vote_sm[2:0];
  assign vote_s   = vote_sm[3] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign vote_w   = {{(W-4){vote_s[3]}}, vote_s};
  assign freq_ext = {{(W-FR_W){freq[FR_W-1]}}, freq};
  assign inc      = vote_w * INT_C;
  assign prop     = vote_w * PROP_C;
  assign fr_sum   = freq_ext + inc;

  always_comb begin
    if (fr_sum > FSAT_P)      fr_sat = FSAT_P;
    else if (fr_sum < FSAT_N) fr_sat = FSAT_N;
    else                      fr_sat = fr_sum;
  end

  assign ph_nx = ph + fr_sat[PH_W-1:0] + prop[PH_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      freq <= '0;
    end else if (vote_vld) begin
      ph   <= ph_nx;
      freq <= fr_sat[FR_W-1:0];
    end
  end

  assign phase_code = ph[PH_W-1 -: CODE_W];

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_vld |=> $stable(phase_code));
  // R3
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_vld |=> $stable(freq));
  // R7
  freq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_ext <= FSAT_P) && (freq_ext >= FSAT_N));
  // R4
  freq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_vld |=> ((freq_ext - $past(freq_ext)) <= STEP_MAX) &&
                 ((freq_ext - $past(freq_ext)) >= -STEP_MAX));
endmodule

// File: tb/tb_cdr_loop_filter.sv
module tb_cdr_loop_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vote_vld = 1'b0;
  logic [3:0] vote_sm = 4'd0;
  logic [5:0] phase_code;

  cdr_loop_filter dut (.clk(clk), .rst_n(rst_n), .vote_vld(vote_vld),
                       .vote_sm(vote_sm), .phase_code(phase_code));

  always #2 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  int    m_freq = 0, m_ph = 0, last_exp = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  seen = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) seen <= vote_vld & rst_n;

  task automatic check(input string tag, input int act, input int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: phase_code=%0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (seen) begin
        if (exp_q.size() == 0) check("R5", int'(phase_code), -1);
        else begin
          last_exp = exp_q.pop_front();
          check(tag_q.pop_front(), int'(phase_code), last_exp);
        end
      end else begin
        check("R3", int'(phase_code), last_exp);
      end
    end
  end

  task automatic vote(input logic [3:0] sm, input string tag);
    int mg, v;
    @(negedge clk);
    vote_vld = 1'b1;
    vote_sm  = sm;
    mg = (int'(sm[2:0]) > 4) ? 4 : int'(sm[2:0]);
    v  = sm[3] ? -mg : mg;
    m_freq = m_freq + 4 * v;
    if (m_freq > 2048)  m_freq = 2048;
    if (m_freq < -2048) m_freq = -2048;
    m_ph = ((m_ph + m_freq + 124 * v) % 16384 + 16384) % 16384;
    exp_q.push_back(m_ph >> 8);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vote_vld = 1'b0;
      vote_sm  = 4'(i * 5 + 3);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    vote_vld = 1'b0;
    rst_n = 1'b0;
    m_freq = 0; m_ph = 0; last_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(phase_code), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 R5: positive step response
    for (int i = 0; i < 20; i++) vote(4'b0100, "R4");
    idle(6);
    // R3: changing vote_sm without valid
    idle(10);
    // R6: negative run wraps downward through 0
    for (int i = 0; i < 60; i++) vote(4'b1100, "R6");
    // R7: long negative run saturates the frequency register
    for (int i = 0; i < 200; i++) vote(4'b1011, "R7");
    idle(4);
    // R7: reverse to positive saturation
    for (int i = 0; i < 400; i++) vote(4'b0100, "R7");
    // R2: clamped magnitudes and negative zero
    for (int i = 0; i < 20; i++) vote(4'b1111, "R2");
    for (int i = 0; i < 20; i++) vote(4'b0110, "R2");
    for (int i = 0; i < 10; i++) vote(4'b1000, "R2");
    idle(3);
    // R1: reset mid-run
    do_reset();
    // R5: small constant votes
    for (int i = 0; i < 40; i++) vote(4'b0001, "R5");
    for (int i = 0; i < 30; i++) vote(4'b1010, "R5");
    // R5 R6: mixed pseudo-random pattern with gaps
    for (int i = 0; i < 600; i++) begin
      vote(4'((i * 7 + (i >> 3)) % 16), "R5");
      if (i % 13 == 0) idle(1);
    end
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule